// File: doc/BRIEF.md
# Frame Header Address Snooper

This block listens, without driving anything, to the 36-bit write bus that a switch controller uses to store packet buffers in memory. It uses the buffer-start marker, the flag bits in the upper nibble of each word, and the order of words inside a buffer to find the first buffer of each packet frame. Buffers that carry index data instead of packet data are skipped. From a packet header it takes the 4-bit channel code, and it rebuilds the 48-bit destination and source MAC addresses. In memory these addresses are spread over three words with their bytes in an unusual order.

When the destination address is complete, the block gives a one-clock destination strobe together with the address and the channel code. One word later it gives a one-clock source strobe together with the source address. An address-table lookup engine placed next to the block consumes these values. The destination strobe follows the start-of-frame word by two clocks, which keeps the lookup well inside a sub-microsecond budget. The captured values stay on the outputs until the next complete capture replaces them.

Top module: `hdr_addr_snoop`

## Requirements
- R1: While `rst` is high and after its release, `da_ready` and `sa_ready` are 0 and `da_addr`, `da_chan` and `sa_addr` are all zero.
- R2: A buffer begins on a clock with `wr_valid` and `wr_first` both high (word 0). If bit 35 of word 0 is 1, the buffer holds index data and is ignored completely: no strobe is issued and no output changes.
- R3: `da_chan` takes the value of bits 27:24 of word 0. Bits 35:32 of words 2 and 3 may also carry a channel copy; that copy is ignored.
- R4: Word 1 is the next valid clock after word 0. It is a start of frame only if its bits 35:34 equal 2'b01. Any other value abandons the buffer, and neither strobe is issued.
- R5: The destination address is assembled byte by byte. Word 1 bits 7:0, 15:8, 23:16 and 31:24 give DA[47:40], DA[39:32], DA[31:24] and DA[23:16]. Word 2 bits 7:0 and 15:8 give DA[15:8] and DA[7:0].
- R6: `da_ready` goes high for exactly one clock, in the cycle after the edge that samples word 2. In that same cycle `da_addr` and `da_chan` show the new values. This is two clocks after the start-of-frame word.
- R7: The source address is assembled as follows. Word 2 bits 23:16 and 31:24 give SA[47:40] and SA[39:32]. Word 3 bits 7:0, 15:8, 23:16 and 31:24 give SA[31:24], SA[23:16], SA[15:8] and SA[7:0]. `sa_ready` pulses for one clock in the cycle after word 3, which is always the cycle after a `da_ready` pulse.
- R8: If `wr_valid` is low on any clock between word 0 and word 3, the buffer is abandoned. No strobe is issued for any word that had not been reached.
- R9: If `wr_first` rises in the middle of a buffer, the partial capture is dropped and that word is treated as word 0 of a new buffer.
- R10: Outside their strobe cycles, `da_addr`, `da_chan` and `sa_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A write word is present on the bus this clock |
| wr_first | input | 1 | The word is the first word of a buffer |
| wr_data | input | 36 | Write bus: flags in 35:32, payload in 31:0 |
| da_ready | output | 1 | One-clock strobe: destination address and channel are new |
| da_addr | output | 48 | Captured destination MAC address |
| da_chan | output | 4 | Channel code from the pointer word |
| sa_ready | output | 1 | One-clock strobe: source address is new |
| sa_addr | output | 48 | Captured source MAC address |

## Verification
The bench drives headers whose address bytes are all different. A single misplaced byte in the reassembly therefore shows up directly as a wrong destination or source address, and it also drives a false channel copy in the later words, so a design that reads the channel from the wrong word reports a wrong channel. It sends index buffers, every invalid start-of-frame flag value, and buffers cut short after one, two and three words. A design that ignored the reject bit, the flag test or the gap rule would then pulse a strobe or change an output while it should hold. Buffers are also restarted in the middle and sent back to back with no idle clock between them. A design that stayed in its old word count would then combine two frames or lose the second one.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int BUS_W    = 36;
    localparam int ADDR_W   = 48;
    localparam int CHAN_W   = 4;
    localparam int PAY_W    = 32;
    localparam int IDX_BIT  = 35;
    localparam int FLAG_HI  = 35;
    localparam int FLAG_LO  = 34;
    localparam int CHAN_LSB = 24;
    localparam int HALF_W   = ADDR_W - PAY_W;
    localparam logic [1:0] SOF_CODE = 2'b01;

    typedef enum logic [1:0] {
        W_IDLE,
        W_HDR1,
        W_HDR2,
        W_HDR3
    } word_state_t;

    typedef struct packed {
        logic w0;
        logic w1;
        logic w2;
        logic w3;
    } take_t;

    function automatic logic [PAY_W-1:0] byte_rev32(input logic [PAY_W-1:0] w);
        logic [PAY_W-1:0] r;
        for (int b = 0; b < PAY_W / 8; b++) begin
            r[8*b +: 8] = w[PAY_W - 8*(b+1) +: 8];
        end
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] swap16(input logic [HALF_W-1:0] h);
        return {h[7:0], h[15:8]};
    endfunction

    // DA[47:16] from word 1
    function automatic logic [PAY_W-1:0] da_upper(input logic [BUS_W-1:0] w);
        return byte_rev32(w[PAY_W-1:0]);
    endfunction

    // DA[15:0] from word 2
    function automatic logic [HALF_W-1:0] da_lower(input logic [BUS_W-1:0] w);
        return swap16(w[15:0]);
    endfunction

    // SA[47:32] from word 2
    function automatic logic [HALF_W-1:0] sa_upper(input logic [BUS_W-1:0] w);
        return swap16(w[31:16]);
    endfunction

    // SA[31:0] from word 3
    function automatic logic [PAY_W-1:0] sa_lower(input logic [BUS_W-1:0] w);
        return byte_rev32(w[PAY_W-1:0]);
    endfunction

endpackage

// File: rtl/snoop_seq.sv
module snoop_seq
    import snoop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic             wr_first,
    input  logic [BUS_W-1:0] wr_data,
    output take_t            take
);

    word_state_t state_q, state_d;
    logic        start_ok;
    logic        sof_ok;

    assign start_ok = wr_valid && wr_first && !wr_data[IDX_BIT];
    assign sof_ok   = (wr_data[FLAG_HI:FLAG_LO] == SOF_CODE);

    always_comb begin
        state_d = W_IDLE;
        take    = '0;
        if (wr_valid && wr_first) begin
            if (start_ok) begin
                state_d = W_HDR1;
                take.w0 = 1'b1;
            end
        end else if (wr_valid) begin
            unique case (state_q)
                W_HDR1: if (sof_ok) begin
                    state_d = W_HDR2;
                    take.w1 = 1'b1;
                end
                W_HDR2: begin
                    state_d = W_HDR3;
                    take.w2 = 1'b1;
                end
                W_HDR3: take.w3 = 1'b1;
                default: state_d = W_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= W_IDLE;
        else     state_q <= state_d;
    end

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take.w0, take.w1, take.w2, take.w3})); // R9
    AST_IDX_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_first && wr_data[IDX_BIT]) |=> (state_q == W_IDLE)); // R2
    AST_SOF_GATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == W_HDR1 && wr_valid && !wr_first && !sof_ok) |=> (state_q == W_IDLE)); // R4
    AST_GAP_ABANDON: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid) |=> (state_q == W_IDLE)); // R8

endmodule

// File: rtl/snoop_da_cap.sv
module snoop_da_cap
    import snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  take_t             take,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              da_ready,
    output logic [ADDR_W-1:0] da_addr,
    output logic [CHAN_W-1:0] da_chan
);

    logic [CHAN_W-1:0] chan_stage;
    logic [PAY_W-1:0]  upper_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_stage  <= '0;
            upper_stage <= '0;
            da_ready    <= 1'b0;
            da_addr     <= '0;
            da_chan     <= '0;
        end else begin
            da_ready <= take.w2;
            if (take.w0) chan_stage  <= wr_data[CHAN_LSB +: CHAN_W];
            if (take.w1) upper_stage <= da_upper(wr_data);
            if (take.w2) begin
                da_addr <= {upper_stage, da_lower(wr_data)};
                da_chan <= chan_stage;
            end
        end
    end

    AST_DA_PULSE: assert property (@(posedge clk) disable iff (rst)
        da_ready |=> !da_ready); // R6
    AST_DA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !da_ready |-> ($stable(da_addr) && $stable(da_chan))); // R10

endmodule

// File: rtl/snoop_sa_cap.sv
module snoop_sa_cap
    import snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  take_t             take,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              sa_ready,
    output logic [ADDR_W-1:0] sa_addr
);

    logic [HALF_W-1:0] upper_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_stage <= '0;
            sa_ready    <= 1'b0;
            sa_addr     <= '0;
        end else begin
            sa_ready <= take.w3;
            if (take.w2) upper_stage <= sa_upper(wr_data);
            if (take.w3) sa_addr     <= {upper_stage, sa_lower(wr_data)};
        end
    end

    AST_SA_PULSE: assert property (@(posedge clk) disable iff (rst)
        sa_ready |=> !sa_ready); // R7
    AST_SA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sa_ready |-> $stable(sa_addr)); // R10

endmodule

// File: rtl/hdr_addr_snoop.sv
module hdr_addr_snoop
    import snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic              wr_first,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              da_ready,
    output logic [ADDR_W-1:0] da_addr,
    output logic [CHAN_W-1:0] da_chan,
    output logic              sa_ready,
    output logic [ADDR_W-1:0] sa_addr
);

    take_t take;

    snoop_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_first (wr_first),
        .wr_data  (wr_data),
        .take     (take)
    );

    snoop_da_cap u_da (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .wr_data  (wr_data),
        .da_ready (da_ready),
        .da_addr  (da_addr),
        .da_chan  (da_chan)
    );

    snoop_sa_cap u_sa (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .wr_data  (wr_data),
        .sa_ready (sa_ready),
        .sa_addr  (sa_addr)
    );

    AST_SA_FOLLOWS_DA: assert property (@(posedge clk) disable iff (rst)
        sa_ready |-> $past(da_ready)); // R7
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(da_ready && sa_ready)); // R6

endmodule

// File: tb/sim_hdr_addr_snoop.sv
module sim_hdr_addr_snoop;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic        wr_first = 1'b0;
    logic [35:0] wr_data = '0;
    logic        da_ready, sa_ready;
    logic [47:0] da_addr, sa_addr;
    logic [3:0]  da_chan;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [47:0] exp_da = '0;
    logic [47:0] exp_sa = '0;
    logic [3:0]  exp_chan = '0;

    always #10 clk = ~clk;

    hdr_addr_snoop u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_first(wr_first),
        .wr_data(wr_data), .da_ready(da_ready), .da_addr(da_addr),
        .da_chan(da_chan), .sa_ready(sa_ready), .sa_addr(sa_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_w1(input logic [47:0] da);
        return {da[23:16], da[31:24], da[39:32], da[47:40]};
    endfunction
    function automatic logic [31:0] enc_w2(input logic [47:0] da, input logic [47:0] sa);
        return {sa[39:32], sa[47:40], da[7:0], da[15:8]};
    endfunction
    function automatic logic [31:0] enc_w3(input logic [47:0] sa);
        return {sa[7:0], sa[15:8], sa[23:16], sa[31:24]};
    endfunction

    task automatic drive(input logic [35:0] w, input bit first);
        wr_valid = 1'b1;
        wr_first = first;
        wr_data  = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_cycle(input string req);
        wr_valid = 1'b0;
        wr_first = 1'b0;
        wr_data  = 36'($urandom());
        @(posedge clk);
        @(negedge clk);
        chk(da_ready == 1'b0, req, "da_ready after idle", 64'(da_ready), 64'(0));
        chk(sa_ready == 1'b0, req, "sa_ready after idle", 64'(sa_ready), 64'(0));
        chk(da_addr == exp_da, req, "da_addr held", 64'(da_addr), 64'(exp_da));
        chk(sa_addr == exp_sa, req, "sa_addr held", 64'(sa_addr), 64'(exp_sa));
    endtask

    task automatic run_frame(input bit idx, input logic [1:0] flag, input logic [3:0] chan,
                             input logic [47:0] da, input logic [47:0] sa,
                             input int nwords, input bit gap);
        logic [35:0] w [4];
        bit good;
        string why;
        good = !idx && (flag == 2'b01);
        why  = idx ? "R2" : ((flag != 2'b01) ? "R4" : "R5");
        w[0] = {idx, 7'($urandom()), chan, 24'($urandom())};
        w[1] = {flag, 2'($urandom()), enc_w1(da)};
        w[2] = {~chan, enc_w2(da, sa)};
        w[3] = {~chan, enc_w3(sa)};
        for (int k = 0; k < nwords; k++) begin
            drive(w[k], k == 0);
            if (k < 2) begin
                chk(da_ready == 1'b0, why, "early da_ready", 64'(da_ready), 64'(0));
                chk(sa_ready == 1'b0, why, "early sa_ready", 64'(sa_ready), 64'(0));
            end else if (k == 2) begin
                if (good) begin
                    chk(da_ready == 1'b1, "R6", "da_ready after word 2", 64'(da_ready), 64'(1));
                    chk(da_addr == da, "R5", "da_addr", 64'(da_addr), 64'(da));
                    chk(da_chan == chan, "R3", "da_chan", 64'(da_chan), 64'(chan));
                    exp_da = da;
                    exp_chan = chan;
                end else begin
                    chk(da_ready == 1'b0, why, "no da_ready", 64'(da_ready), 64'(0));
                    chk(da_addr == exp_da, why, "da_addr unchanged", 64'(da_addr), 64'(exp_da));
                    chk(da_chan == exp_chan, why, "da_chan unchanged", 64'(da_chan), 64'(exp_chan));
                end
            end else begin
                chk(da_ready == 1'b0, "R6", "da_ready one clock", 64'(da_ready), 64'(0));
                if (good) begin
                    chk(sa_ready == 1'b1, "R7", "sa_ready after word 3", 64'(sa_ready), 64'(1));
                    chk(sa_addr == sa, "R7", "sa_addr", 64'(sa_addr), 64'(sa));
                    exp_sa = sa;
                end else begin
                    chk(sa_ready == 1'b0, why, "no sa_ready", 64'(sa_ready), 64'(0));
                    chk(sa_addr == exp_sa, why, "sa_addr unchanged", 64'(sa_addr), 64'(exp_sa));
                end
            end
        end
        if (gap) idle_cycle(nwords < 4 ? "R8" : "R10");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state while reset is high
        chk(!da_ready && !sa_ready, "R1", "strobes in reset", 64'({da_ready, sa_ready}), 64'(0));
        chk(da_addr == 0 && sa_addr == 0 && da_chan == 0, "R1", "outputs in reset",
            64'(da_addr ^ sa_addr), 64'(0));
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!da_ready && !sa_ready && da_addr == 0, "R1", "after release",
            64'({da_ready, sa_ready}), 64'(0));

        // distinct bytes everywhere
        run_frame(1'b0, 2'b01, 4'hA, 48'h0123_4567_89AB, 48'hCDEF_1357_9BDF, 4, 1'b1);
        run_frame(1'b0, 2'b01, 4'h5, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001, 4, 1'b1);
        // R2 index buffer ignored
        run_frame(1'b1, 2'b01, 4'h3, 48'h1111_2222_3333, 48'h4444_5555_6666, 4, 1'b1);
        // R4 all invalid flag values
        run_frame(1'b0, 2'b00, 4'h7, 48'hA1A2_A3A4_A5A6, 48'hB1B2_B3B4_B5B6, 4, 1'b1);
        run_frame(1'b0, 2'b10, 4'h7, 48'hA1A2_A3A4_A5A6, 48'hB1B2_B3B4_B5B6, 4, 1'b1);
        run_frame(1'b0, 2'b11, 4'h7, 48'hA1A2_A3A4_A5A6, 48'hB1B2_B3B4_B5B6, 4, 1'b1);
        // R8 truncation after 1, 2, 3 words
        run_frame(1'b0, 2'b01, 4'h9, 48'h0F0E_0D0C_0B0A, 48'h1F1E_1D1C_1B1A, 1, 1'b1);
        run_frame(1'b0, 2'b01, 4'h9, 48'h0F0E_0D0C_0B0A, 48'h1F1E_1D1C_1B1A, 2, 1'b1);
        run_frame(1'b0, 2'b01, 4'h9, 48'h0F0E_0D0C_0B0A, 48'h1F1E_1D1C_1B1A, 3, 1'b1);
        // R9 restart in mid buffer: after word 1, then after word 2
        run_frame(1'b0, 2'b01, 4'h2, 48'h2222_2222_2222, 48'h3333_3333_3333, 2, 1'b0);
        run_frame(1'b0, 2'b01, 4'hC, 48'h5A5B_5C5D_5E5F, 48'h6A6B_6C6D_6E6F, 4, 1'b0);
        chk(da_addr == 48'h5A5B_5C5D_5E5F && da_chan == 4'hC, "R9", "restart after word 1",
            64'(da_addr), 64'(48'h5A5B_5C5D_5E5F));
        run_frame(1'b0, 2'b01, 4'h4, 48'h7777_7777_7777, 48'h8888_8888_8888, 3, 1'b0);
        run_frame(1'b0, 2'b01, 4'hE, 48'h9192_9394_9596, 48'hC1C2_C3C4_C5C6, 4, 1'b0);
        chk(sa_addr == 48'hC1C2_C3C4_C5C6, "R9", "restart after word 2",
            64'(sa_addr), 64'(48'hC1C2_C3C4_C5C6));
        idle_cycle("R10");

        // constrained random mix
        for (int i = 0; i < 80; i++) begin
            bit idx;
            logic [1:0] flag;
            int nw;
            idx  = ($urandom_range(7) == 0);
            flag = ($urandom_range(5) == 0) ? 2'($urandom()) : 2'b01;
            nw   = ($urandom_range(4) == 0) ? int'($urandom_range(1, 3)) : 4;
            run_frame(idx, flag, 4'($urandom()), {16'($urandom()), 32'($urandom())},
                      {16'($urandom()), 32'($urandom())}, nw, $urandom_range(1) == 1);
        end
        idle_cycle("R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule